// File: doc/BRIEF.md
# Partition-Interleaved Frame Readout Serializer

This block drains one stored row of a frame from a readable frame buffer and feeds it to a display that is cut into equal horizontal partitions, all of them loaded in parallel. The buffer is laid out partition by partition. Each partition holds `ROWS` rows of `ROW_BYTES` bytes, and each byte carries eight pixels. For every byte position of the selected column window, the block reads one byte from each partition in turn. It then shifts all of those bytes out together, one serial lane per partition. Every lane therefore carries the same screen position at the same moment, and the rate on each lane is one sixteenth of the total pixel rate.

A one-cycle `start` pulse launches one row. The block reads and shifts every selected position of that row, raises `row_done` for one cycle, advances its internal row counter (wrapping after the last row of a partition), and then waits for the next `start`. The buffer read port must return the addressed byte on `rd_data` one clock after `rd_en`/`rd_addr`, which is the behaviour of a registered block RAM.

Top module: `part_readout_ser`

## Requirements
- R1: While reset is high and on the first cycle after it, `rd_en`, `shift_en`, `row_done`, `busy` and every bit of `ser_data` are 0.
- R2: Each read presents the address `(p*ROWS + r)*ROW_BYTES + c`, where p is the partition, r is the current row and c is the byte column. Within one column the partitions are read in increasing order, 0 to LANES-1, so that consecutive reads differ by `ROWS*ROW_BYTES`.
- R3: Only the columns `COL_FIRST` to `COL_FIRST+COL_COUNT-1` are read, in increasing order. No other column address appears.
- R4: For each position, lane p (`ser_data[p]`) carries the byte read from partition p. The bits come most significant first, on eight consecutive cycles in which `shift_en` is 1. All lanes show the same bit index in the same cycle.
- R5: `shift_en` is never 1 in a cycle where `rd_en` is 1. A row produces exactly `8*COL_COUNT` cycles of `shift_en`.
- R6: `row_done` is 1 for exactly one cycle, in the cycle right after the last `shift_en` of the row. The next row then uses row r+1, or row 0 after row `ROWS-1`.
- R7: With `busy` at 0, `rd_en` and `shift_en` stay 0. A `start` pulse that arrives while `busy` is 1 is ignored and does not trigger a further row.
- R8: `busy` becomes 1 in the cycle after an accepted `start`. It is 0 in the cycle in which `row_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches the readout of one row |
| rd_en | output | 1 | Read strobe to the frame buffer |
| rd_addr | output | ADDR_W | Frame buffer read address |
| rd_data | input | BYTE_W | Byte returned one cycle after the read strobe |
| ser_data | output | LANES | One serial data lane per partition |
| shift_en | output | 1 | Shift clock enable; lanes valid when 1 |
| row_done | output | 1 | One-cycle strobe after the last bit of a row |
| busy | output | 1 | Row readout in progress |

## Verification
The assertions rely on `start` being honoured only from the idle state. They also rely on reads being issued as one unbroken burst of LANES per column, because the stride check compares each read with the read in the cycle before it. The buffer model in the bench returns a byte computed from the address one cycle after each strobe, which matches the latency the design expects. The stimulus pulses `start` only as single cycles: once from idle, and once deliberately in the middle of a row so that the ignore rule is exercised. It runs three rows on a two-row configuration so that the row counter wraps.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } prs_state_t;
endpackage

// File: rtl/prs_addr_calc.sv
module prs_addr_calc #(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 32,
  parameter int PART_W    = 4,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 5,
  parameter int ADDR_W    = 13
) (
  input  logic [PART_W-1:0] part,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] addr
);
  // Partition-major layout: partition block, then row, then byte column.
  always_comb begin
    addr = (ADDR_W'(part) * ADDR_W'(ROWS) + ADDR_W'(row)) * ADDR_W'(ROW_BYTES)
           + ADDR_W'(col);
  end
endmodule

// File: rtl/prs_lane_bank.sv
module prs_lane_bank #(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8,
  parameter int PART_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PART_W-1:0] load_idx,
  input  logic [BYTE_W-1:0] din,
  input  logic              shift,
  output logic [LANES-1:0]  ser
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] sr_q;
    logic              ser_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sr_q  <= '0;
        ser_q <= 1'b0;
      end else begin
        if (load && (load_idx == PART_W'(i))) sr_q <= din;
        else if (shift) sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
        ser_q <= shift ? sr_q[BYTE_W-1] : 1'b0;
      end
    end
    assign ser[i] = ser_q;
  end

  // R5
  no_load_in_shift_chk: assert property (@(posedge clk) disable iff (rst)
    shift |-> !load);
endmodule

// File: rtl/part_readout_ser.sv
module part_readout_ser
  import prs_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 32,
  parameter int COL_FIRST = 0,
  parameter int COL_COUNT = 32,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = $clog2(LANES * ROWS * ROW_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [LANES-1:0]  ser_data,
  output logic              shift_en,
  output logic              row_done,
  output logic              busy
);
  localparam int PART_W   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W    = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;
  localparam int IDX_W    = $clog2(LANES + 2);
  localparam int BIT_W    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int COL_LAST = COL_FIRST + COL_COUNT - 1;
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ROWS * ROW_BYTES);

  prs_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [COL_W-1:0]  col_q;
  logic [ROW_W-1:0]  row_q;
  logic [BIT_W-1:0]  bit_q;
  logic              v1_q, v2_q;
  logic [PART_W-1:0] l1_q, l2_q;
  logic              rd_en_q, shift_en_q, row_done_q, busy_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [ADDR_W-1:0] addr_c;
  logic [PART_W-1:0] part_c;

  assign part_c = idx_q[PART_W-1:0];

  prs_addr_calc #(
    .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .PART_W(PART_W),
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .part(part_c), .row(row_q), .col(col_q), .addr(addr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      col_q      <= COL_W'(COL_FIRST);
      row_q      <= '0;
      bit_q      <= '0;
      v1_q       <= 1'b0;
      v2_q       <= 1'b0;
      l1_q       <= '0;
      l2_q       <= '0;
      rd_en_q    <= 1'b0;
      rd_addr_q  <= '0;
      shift_en_q <= 1'b0;
      row_done_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      rd_en_q    <= 1'b0;
      shift_en_q <= 1'b0;
      row_done_q <= 1'b0;
      v1_q       <= 1'b0;
      v2_q       <= v1_q;
      l2_q       <= l1_q;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_FETCH;
            idx_q   <= '0;
            col_q   <= COL_W'(COL_FIRST);
            busy_q  <= 1'b1;
          end
        end
        ST_FETCH: begin
          // Issue one read per partition; capture trails issue by two cycles.
          if (idx_q < IDX_W'(LANES)) begin
            rd_en_q   <= 1'b1;
            rd_addr_q <= addr_c;
            v1_q      <= 1'b1;
            l1_q      <= part_c;
          end
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(LANES + 1)) begin
            state_q <= ST_SHIFT;
            bit_q   <= '0;
          end
        end
        ST_SHIFT: begin
          shift_en_q <= 1'b1;
          bit_q      <= bit_q + 1'b1;
          if (bit_q == BIT_W'(BYTE_W - 1)) begin
            if (col_q == COL_W'(COL_LAST)) begin
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_FETCH;
              idx_q   <= '0;
              col_q   <= col_q + 1'b1;
            end
          end
        end
        ST_DONE: begin
          row_done_q <= 1'b1;
          busy_q     <= 1'b0;
          state_q    <= ST_IDLE;
          row_q      <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  prs_lane_bank #(
    .LANES(LANES), .BYTE_W(BYTE_W), .PART_W(PART_W)
  ) u_lanes (
    .clk(clk), .rst(rst),
    .load(v2_q), .load_idx(l2_q), .din(rd_data),
    .shift(state_q == ST_SHIFT),
    .ser(ser_data)
  );

  assign rd_en    = rd_en_q;
  assign rd_addr  = rd_addr_q;
  assign shift_en = shift_en_q;
  assign row_done = row_done_q;
  assign busy     = busy_q;

  // R6
  row_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    row_done |=> !row_done);
  // R8
  busy_low_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    row_done |-> !busy);
  // R5
  no_read_during_shift_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !shift_en);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_en && !shift_en));
  // R2
  partition_stride_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && l1_q != '0) |-> (rd_addr == $past(rd_addr) + STRIDE));
endmodule

// File: tb/sim_part_readout_ser.sv
module sim_part_readout_ser;
  localparam int LANES = 16, ROWS = 2, RB = 4, CF = 1, CC = 2, BW = 8;
  localparam int AW = $clog2(LANES * ROWS * RB);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic rd_en, shift_en, row_done, busy;
  logic [AW-1:0] rd_addr;
  logic [BW-1:0] rd_data = '0;
  logic [LANES-1:0] ser_data;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int a_part = 0, a_col = CF, a_row = 0;
  int s_col = CF, s_row = 0, s_bit = 0, row_bits = 0, rows_seen = 0, pos_seen = 0;
  logic prev_sh = 1'b0;
  logic [BW-1:0] acc [LANES];

  always #5 clk = ~clk;

  part_readout_ser #(.LANES(LANES), .ROWS(ROWS), .ROW_BYTES(RB),
    .COL_FIRST(CF), .COL_COUNT(CC), .BYTE_W(BW)) u0 (
    .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .ser_data(ser_data), .shift_en(shift_en),
    .row_done(row_done), .busy(busy));

  function automatic logic [BW-1:0] mem_byte(int a);
    return BW'((a * 29 + 7) ^ (a >> 3));
  endfunction

  function automatic int exp_addr(int p, int r, int c);
    return (p * ROWS + r) * RB + c;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_byte(int'(rd_addr));

  task automatic check(string req, logic ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  // Monitor: read order, lane contents, row strobe
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en) begin
        // R2 R3 interleaved partition order inside selected columns
        check("R2/R3 addr", int'(rd_addr) == exp_addr(a_part, a_row, a_col),
              int'(rd_addr), exp_addr(a_part, a_row, a_col));
        a_part++;
        if (a_part == LANES) begin
          a_part = 0; a_col++;
          if (a_col == CF + CC) begin a_col = CF; a_row = (a_row + 1) % ROWS; end
        end
        if (shift_en) check("R5 overlap", 1'b0, 1, 0);
      end
      if (shift_en) begin
        for (int p = 0; p < LANES; p++) acc[p] = {acc[p][BW-2:0], ser_data[p]};
        s_bit++; row_bits++;
        if (s_bit == BW) begin
          // R4 each lane carries its partition's byte, MSB first
          for (int p = 0; p < LANES; p++) begin
            if (acc[p] != mem_byte(exp_addr(p, s_row, s_col))) begin
              check("R4 lane byte", 1'b0, int'(acc[p]),
                    int'(mem_byte(exp_addr(p, s_row, s_col))));
              break;
            end
            if (p == LANES - 1) check("R4 lane byte", 1'b1, 0, 0);
          end
          s_bit = 0; pos_seen++; s_col++;
          if (s_col == CF + CC) begin s_col = CF; s_row = (s_row + 1) % ROWS; end
        end
      end
      if (row_done) begin
        // R6 strobe right after last shift; R5 bit count; R8 busy low
        check("R6 strobe timing", prev_sh, int'(prev_sh), 1);
        check("R5 shifts per row", row_bits == BW * CC, row_bits, BW * CC);
        check("R8 busy at done", !busy, int'(busy), 0);
        row_bits = 0; rows_seen++;
      end
      prev_sh = shift_en;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_row();
    while (!row_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset values
    check("R1 reset", {rd_en, shift_en, row_done, busy, ser_data} == '0,
          int'({rd_en, shift_en, row_done, busy}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {rd_en, shift_en, row_done, busy, ser_data} == '0,
          int'({rd_en, shift_en, row_done, busy}), 0);
    repeat (10) @(negedge clk);
    // R7 idle without start
    check("R7 idle", !busy && !rd_en && !shift_en, int'(busy), 0);

    pulse_start();
    check("R8 busy after start", busy, int'(busy), 1);
    wait_row();

    pulse_start();
    check("R8 busy after start", busy, int'(busy), 1);
    repeat (30) @(negedge clk);
    pulse_start();  // R7 ignored while busy
    wait_row();
    repeat (5) @(negedge clk);
    check("R7 start ignored", !busy && !rd_en, int'(busy), 0);
    check("R7 rows so far", rows_seen == 2, rows_seen, 2);

    pulse_start();  // R6 row counter wraps back to row 0
    check("R8 busy after start", busy, int'(busy), 1);
    wait_row();
    repeat (3) @(negedge clk);
    check("R6 rows total", rows_seen == 3, rows_seen, 3);
    check("R3 positions total", pos_seen == 3 * CC, pos_seen, 3 * CC);
    check("R2 read order closed", a_part == 0 && a_col == CF, a_part, 0);
    finish_run();
  end
endmodule